// File: doc/BRIEF.md
# Overlapped-Grant Central Bus Arbiter

This block decides which of several masters may next drive a shared, multiplexed parallel bus. Each master pulls its own active-low request line and watches its own active-low grant line. A grant is permission to begin the next transaction once the bus goes idle. The grant does not transfer ownership on its own. Because the next grant can be issued while another master's transaction is still running, there are no idle arbitration cycles between back-to-back transfers. Ownership changes only when the framing and ready signals are both released.

Requests compete in a rotating priority order. The master after the last one granted ranks highest, so a master that requests without pause cannot starve the others. A master that has been granted keeps the grant until one of three things happens: it starts a transaction and someone else is waiting, it withdraws its request, or it stays silent for too many idle bus cycles. Between two different grant holders there is always one cycle with no grant asserted. When nobody requests, the grant parks on master 0.

Top module: `bar_arbiter`

## Requirements
- R1: While reset is held low, every bit of `gnt_n` is 1, meaning no master is granted.
- R2: At most one bit of `gnt_n` is 0 in any cycle. Bit k at 0 means master k holds the grant, and a request is bit k of `req_n` at 0.
- R3: Between two different grant holders, and before a holder is re-granted, `gnt_n` is all ones for at least one cycle.
- R4: When no grant is held and at least one request is present, the grant appears on the next clock edge. It goes to the first requester found by scanning upward, with wrap-around, from the master after the last one granted. After reset the scan starts at master 0. Parking does not move the scan position.
- R5: A granted master that keeps requesting and has not yet started a transaction keeps its grant while other masters request, as long as its idle allowance has not run out.
- R6: A transaction start is the first clock edge on which `frame_n` is 0 after an edge on which `frame_n` and `irdy_n` were both 1. Once the holder has started, a pending request from another master removes the grant on the following edge. The next grant is then issued one edge later, even if `frame_n` is still 0.
- R7: A holder that has started a transaction and is the only requester keeps its grant, so it can run back-to-back transfers.
- R8: A holder other than master 0 that stops requesting loses its grant on the next edge. Master 0 holding a parked grant without requesting loses it as soon as any other master requests.
- R9: With no grant held and no request present, the grant is given to master 0 on the next edge and stays there while no one requests.
- R10: A requesting holder that has not started a transaction loses its grant on its 16th idle bus cycle (`IDLE_LIMIT`). Counting starts from the cycle in which the grant first appears. The arbiter then re-arbitrates.
- R11: The bus counts as idle only in a cycle where `frame_n` and `irdy_n` are both 1. Cycles where the bus is busy do not advance the idle allowance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; everything updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N_MASTERS | Active-low request, one bit per master |
| frame_n | input | 1 | Active-low transaction framing signal observed on the bus |
| irdy_n | input | 1 | Active-low initiator-ready signal observed on the bus |
| gnt_n | output | N_MASTERS | Active-low grant, one bit per master, registered |

## Verification
Every grant change is registered, so a new request pattern shows up on `gnt_n` one rising edge later. A transaction start is recognised on the edge that first samples `frame_n` low. The holder's grant is removed on the edge after that, and the next holder appears one edge further on. Timeouts surface after sixteen counted idle edges, and busy cycles add nothing to that count. The bench drives inputs and samples `gnt_n` on falling edges, and it counts the rising edges between a stimulus and the sample at which each of these results is due. The timeout is checked by counting consecutive granted samples against the arithmetic figure: 16 when counting from the first grant sample, and 15 when counting from the release of a busy bus.

// File: rtl/bar_pkg.sv
package bar_pkg;

  // Action the grant register takes on the next clock edge
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_RELEASE = 2'd1,
    ACT_GRANT   = 2'd2,
    ACT_PARK    = 2'd3
  } arb_act_e;

  // Modular wrap used by the rotating priority scan
  function automatic int unsigned rr_wrap(int unsigned v, int unsigned n);
    return v % n;
  endfunction

  // Grant policy: one decision per cycle from the current holder's situation
  function automatic arb_act_e choose_act(
    logic held,
    logic holder_req,
    logic holder_is_zero,
    logic any_req,
    logic others_req,
    logic used,
    logic expired
  );
    if (!held)
      return any_req ? ACT_GRANT : ACT_PARK;
    if (!holder_req)
      return (any_req || !holder_is_zero) ? ACT_RELEASE : ACT_HOLD;
    if (expired)
      return ACT_RELEASE;
    if (used && others_req)
      return ACT_RELEASE;
    return ACT_HOLD;
  endfunction

endpackage

// File: rtl/bar_rr_pick.sv
module bar_rr_pick #(
  parameter int N_MASTERS = 4,
  parameter int IW        = 2
) (
  input  logic [N_MASTERS-1:0] req,
  input  logic [IW-1:0]        ptr,
  output logic [IW-1:0]        win_idx,
  output logic                 win_vld
);

  // Requests rotated so that offset 0 is the highest-priority slot
  logic [N_MASTERS-1:0] rot;
  logic [IW-1:0]        off;

  for (genvar k = 0; k < N_MASTERS; k++) begin : g_rot
    logic [IW-1:0] slot;
    assign slot   = IW'(bar_pkg::rr_wrap(int'(ptr) + k, N_MASTERS));
    assign rot[k] = req[slot];
  end

  always_comb begin
    off = '0;
    for (int k = N_MASTERS - 1; k >= 0; k--) begin
      if (rot[k]) off = IW'(k);
    end
  end

  assign win_vld = |rot;
  assign win_idx = IW'(bar_pkg::rr_wrap(int'(ptr) + int'(off), N_MASTERS));

endmodule

// File: rtl/bar_bus_mon.sv
module bar_bus_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic bus_idle,
  output logic txn_start
);

  logic idle_q;

  assign bus_idle = frame_n & irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b1;
    else        idle_q <= bus_idle;
  end

  // Framing asserted right after an idle cycle opens a new transaction
  assign txn_start = idle_q & ~frame_n;

endmodule

// File: rtl/bar_wait_timer.sv
module bar_wait_timer #(
  parameter int LIMIT = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  output logic          expired,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_q;

  assign expired = tick & (cnt_q == CW'(LIMIT - 1));
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/bar_arbiter.sv
module bar_arbiter #(
  parameter int N_MASTERS  = 4,
  parameter int IDLE_LIMIT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_n,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  output logic [N_MASTERS-1:0] gnt_n
);

  import bar_pkg::*;

  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
  localparam int CW = $clog2(IDLE_LIMIT + 1);

  logic [N_MASTERS-1:0] req;
  logic [N_MASTERS-1:0] holder_mask;
  logic                 gnt_vld_q;
  logic [IW-1:0]        gnt_idx_q;
  logic [IW-1:0]        ptr_q;
  logic [IW-1:0]        ptr_after;
  logic                 used_q;
  logic                 used_d;
  logic                 holder_req;
  logic                 others_req;
  logic                 any_req;
  logic [IW-1:0]        win_idx;
  logic                 win_vld;
  logic                 bus_idle;
  logic                 txn_start;
  logic                 wait_tick;
  logic                 wait_clear;
  logic                 wait_expired;
  logic [CW-1:0]        idle_cnt;
  arb_act_e             act;

  assign req = ~req_n;

  always_comb begin
    holder_mask = '0;
    if (gnt_vld_q) holder_mask[gnt_idx_q] = 1'b1;
  end

  assign holder_req = |(req & holder_mask);
  assign others_req = |(req & ~holder_mask);
  assign any_req    = |req;

  bar_rr_pick #(
    .N_MASTERS(N_MASTERS),
    .IW       (IW)
  ) u_pick (
    .req    (req),
    .ptr    (ptr_q),
    .win_idx(win_idx),
    .win_vld(win_vld)
  );

  bar_bus_mon u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .bus_idle (bus_idle),
    .txn_start(txn_start)
  );

  // Idle allowance only drains for a requesting holder that has not started
  assign wait_tick = gnt_vld_q & holder_req & ~used_q & bus_idle;

  bar_wait_timer #(
    .LIMIT(IDLE_LIMIT),
    .CW   (CW)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (wait_clear),
    .tick   (wait_tick),
    .expired(wait_expired),
    .count  (idle_cnt)
  );

  assign act = choose_act(gnt_vld_q, holder_req, gnt_idx_q == '0, any_req,
                          others_req, used_q, wait_expired);

  assign wait_clear = (act != ACT_HOLD);
  assign used_d     = (act == ACT_HOLD) & (used_q | txn_start);
  assign ptr_after  = IW'(rr_wrap(int'(win_idx) + 1, N_MASTERS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_vld_q <= 1'b0;
      gnt_idx_q <= '0;
      ptr_q     <= '0;
      used_q    <= 1'b0;
    end else begin
      used_q <= used_d;
      case (act)
        ACT_RELEASE: gnt_vld_q <= 1'b0;
        ACT_GRANT: begin
          if (win_vld) begin
            gnt_vld_q <= 1'b1;
            gnt_idx_q <= win_idx;
            ptr_q     <= ptr_after;
          end
        end
        ACT_PARK: begin
          gnt_vld_q <= 1'b1;
          gnt_idx_q <= '0;
        end
        default: ;
      endcase
    end
  end

  assign gnt_n = ~holder_mask;

endmodule

// File: rtl/bar_arbiter_chk.sv
module bar_arbiter_chk #(
  parameter int N_MASTERS  = 4,
  parameter int IDLE_LIMIT = 16,
  parameter int CW         = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req_n,
  input logic [N_MASTERS-1:0] gnt_n,
  input logic                 txn_used,
  input logic                 others_req,
  input logic                 wait_expired,
  input logic [CW-1:0]        idle_cnt
);

  localparam logic [N_MASTERS-1:0] M0 = N_MASTERS'(1);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (&gnt_n));

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R3
  dead_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != '1) |=> (gnt_n == $past(gnt_n) || (&gnt_n)));

  // R6
  used_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_used && others_req) |=> (&gnt_n));

  // R8
  withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~gnt_n & req_n & ~M0) != '0) |=> (&gnt_n));

  // R9
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&gnt_n) && (&req_n)) |=> (gnt_n == ~M0));

  // R10
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt < CW'(IDLE_LIMIT));

  // R10
  timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_expired |=> (&gnt_n));

endmodule

bind bar_arbiter bar_arbiter_chk #(
  .N_MASTERS (N_MASTERS),
  .IDLE_LIMIT(IDLE_LIMIT),
  .CW        (CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_n       (req_n),
  .gnt_n       (gnt_n),
  .txn_used    (used_q),
  .others_req  (others_req),
  .wait_expired(wait_expired),
  .idle_cnt    (idle_cnt)
);

// File: tb/test_bar_arbiter.sv
`timescale 1ns/1ps
module test_bar_arbiter;

  localparam int NM  = 4;
  localparam int LIM = 16;

  logic          clk;
  logic          rst_n;
  logic [NM-1:0] req_n;
  logic          frame_n;
  logic          irdy_n;
  logic [NM-1:0] gnt_n;

  int n_chk;
  int n_fail;

  bar_arbiter #(.N_MASTERS(NM), .IDLE_LIMIT(LIM)) i_bar_arbiter (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_n  (req_n),
    .frame_n(frame_n),
    .irdy_n (irdy_n),
    .gnt_n  (gnt_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [NM-1:0] g(int i);
    return ~(NM'(1) << i);
  endfunction

  function automatic int first_from(logic [NM-1:0] p, int start);
    for (int k = 0; k < NM; k++) begin
      if (p[(start + k) % NM]) return (start + k) % NM;
    end
    return -1;
  endfunction

  task automatic expect_gnt(input logic [NM-1:0] exp, input string tag);
    n_chk++;
    if (gnt_n !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt_n actual %b expected %b", tag, gnt_n, exp);
    end
  endtask

  task automatic expect_int(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [NM-1:0] pattern);
    rst_n   = 1'b0;
    req_n   = ~pattern;
    frame_n = 1'b1;
    irdy_n  = 1'b1;
    repeat (2) @(negedge clk);
    expect_gnt('1, "R1 reset quiet");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Entered at a falling edge with master m granted and the bus idle
  task automatic run_txn(input int m);
    int nx;
    nx = (m + 1) % NM;
    frame_n = 1'b0;
    irdy_n  = 1'b0;
    @(negedge clk);
    expect_gnt(g(m), "R6 holder keeps grant on start edge");
    @(negedge clk);
    expect_gnt('1, "R3 empty cycle before next holder");
    @(negedge clk);
    expect_gnt(g(nx), "R4 R6 rotated grant while frame busy");
    frame_n = 1'b1;
    @(negedge clk);
    expect_gnt(g(nx), "R11 busy bus keeps waiting grant");
    irdy_n = 1'b1;
    @(negedge clk);
    expect_gnt(g(nx), "R5 unstarted holder keeps grant");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    n_chk   = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    req_n   = '1;
    frame_n = 1'b1;
    irdy_n  = 1'b1;

    // R1 / R4: every request pattern from reset, scan starts at master 0
    for (int p = 1; p < (1 << NM); p++) begin
      do_reset(NM'(p));
      expect_gnt(g(first_from(NM'(p), 0)), "R4 first grant after reset");
    end

    // R5: holder 0 keeps grant while master 1 also waits
    do_reset(4'b0011);
    expect_gnt(g(0), "R4 grant to master 0");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      expect_gnt(g(0), "R5 hold under competition");
    end

    // R4 / R6: all masters request, grant rotates with overlap
    req_n = '0;
    for (int n = 0; n < 8; n++) run_txn(n % NM);

    // R7: lone requester keeps grant through and after its transfer
    do_reset(4'b0100);
    expect_gnt(g(2), "R4 lone master 2");
    frame_n = 1'b0;
    irdy_n  = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      expect_gnt(g(2), "R7 back-to-back holder");
      if (i == 2) frame_n = 1'b1;
      if (i == 3) irdy_n = 1'b1;
    end

    // R8 / R9: withdraw, then park on master 0
    req_n = '1;
    @(negedge clk);
    expect_gnt('1, "R8 withdrawn holder released");
    @(negedge clk);
    expect_gnt(g(0), "R9 park on master 0");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_gnt(g(0), "R9 stays parked");
    end

    // R8 / R10: master 3 requests and never starts
    req_n = 4'b0111;
    @(negedge clk);
    expect_gnt('1, "R8 parked master 0 yields");
    @(negedge clk);
    expect_gnt(g(3), "R4 grant to master 3");
    cnt = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (gnt_n !== g(3)) break;
      cnt++;
    end
    expect_int(cnt, LIM, "R10 granted idle samples before timeout");
    expect_gnt('1, "R10 grant removed on timeout");
    @(negedge clk);
    expect_gnt(g(3), "R10 re-arbitration regrants master 3");

    // R11: busy bus freezes the allowance
    irdy_n = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      expect_gnt(g(3), "R11 no timeout while busy");
    end
    irdy_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (gnt_n !== g(3)) break;
      cnt++;
    end
    expect_int(cnt, LIM - 1, "R11 allowance resumes after busy period");
    expect_gnt('1, "R10 timeout after busy period");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule